// File: doc/BRIEF.md
# Lockable Clock Output Disable Register

This block is a small control register that holds the output-disable state of three buffered clock pins: a crystal-buffer clock, a mid-rate clock and a low-rate clock. A host writes a three-bit value through a single-cycle write strobe. Each bit set to 1 turns off the matching pin driver, and each bit cleared to 0 turns it back on. The block provides registered, active-high output enables that the pad drivers use to tri-state their pins.

The two upper-rate disables can be changed at any time. The low-rate disable is write-once. The first host write after any reset, including a write that stores 0, sets an internal lock. The lock freezes the low-rate bit until the next reset. A hardware reset restores the low-rate clock. Either of two software reset controls also restores it and re-arms the lock. A host write alone cannot re-enable that pin.

Top module: `clk_out_dis_reg`

## Requirements
- R1: Write data bit 0 is the crystal-buffer clock disable. A write stores it, and after the capturing edge `rdData[0]` holds the written value and `oeXtal` equals its inverse.
- R2: Write data bit 1 is the mid-rate clock disable. A write stores it at any time, and after the capturing edge `rdData[1]` holds the written value and `oeMid` equals its inverse.
- R3: The enables `oeXtal`, `oeMid` and `oeLow` are active high. They always equal the inverse of `rdData[0]`, `rdData[1]` and `rdData[2]`, and they change on the same clock edge that captures a write.
- R4: Write data bit 2 is the low-rate clock disable. Only the first write after a reset stores it. Every later write leaves `rdData[2]` and `oeLow` unchanged.
- R5: The first write after a reset locks bit 2 even when that write stores 0.
- R6: A high level on `swResetA` or `swResetB` at a clock edge clears the low-rate disable and the lock, so `oeLow` returns to 1. If a write arrives in the same cycle, the software reset wins for bit 2, while bits 0 and 1 still load from the write.
- R7: In a cycle with no write and no software reset, all three disables and enables hold their values.
- R8: A low level on `rstN` clears all disables and the lock at once, without waiting for a clock edge. All three enables then read 1.
- R9: `rdData` returns the current disables, with bit 0 for the crystal-buffer clock, bit 1 for the mid-rate clock and bit 2 for the low-rate clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| wrEn | input | 1 | Host write strobe, one cycle per write |
| wrData | input | 3 | Host write value (bit 0 crystal, bit 1 mid, bit 2 low) |
| swResetA | input | 1 | First software reset control, level sampled on clk |
| swResetB | input | 1 | Second software reset control, level sampled on clk |
| rdData | output | 3 | Current disable bits |
| oeXtal | output | 1 | Output enable for the crystal-buffer clock pin |
| oeMid | output | 1 | Output enable for the mid-rate clock pin |
| oeLow | output | 1 | Output enable for the low-rate clock pin |

## Verification
Most internal faults in this block become visible one edge after the next write. If the lock flag is stuck clear, a later write to bit 2 changes `rdData[2]` and `oeLow` on the following edge. If the lock is stuck set, or is not set by a zero write, the wrong value appears on the first re-write after reset. If a software reset fails to clear state, `oeLow` stays at 0 on the edge after the reset control is raised. A mismatch between the enable flops and the disable bits shows at once as `oeX` not equal to the inverse of `rdData`. The bench runs the write sequences that expose each of these faults within one or two cycles.

// File: rtl/clk_out_dis_pkg.sv
package clk_out_dis_pkg;
  localparam int DIS_W    = 3;
  localparam int FREE_W   = 2;
  localparam int IDX_XTAL = 0;
  localparam int IDX_MID  = 1;
  localparam int IDX_LOW  = 2;

  typedef struct packed {
    logic loadFree;
    logic loadLow;
    logic clearLow;
  } disStrobe_t;
endpackage

// File: rtl/clk_out_dis_ctrl.sv
module clk_out_dis_ctrl
  import clk_out_dis_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       swResetA,
  input  logic       swResetB,
  output disStrobe_t strobe
);
  logic lockQ;
  logic swClear;

  assign swClear = swResetA | swResetB;

  always_comb begin
    strobe.loadFree = wrEn;
    strobe.clearLow = swClear;
    strobe.loadLow  = wrEn & ~lockQ & ~swClear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lockQ <= 1'b0;
    else if (swClear) lockQ <= 1'b0;
    else if (wrEn)    lockQ <= 1'b1;
  end
endmodule

// File: rtl/clk_out_dis_dp.sv
module clk_out_dis_dp
  import clk_out_dis_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  disStrobe_t       strobe,
  input  logic [DIS_W-1:0] wrData,
  output logic [DIS_W-1:0] disQ,
  output logic [DIS_W-1:0] oeQ
);
  logic [DIS_W-1:0] disNext;

  for (genvar i = 0; i < FREE_W; i++) begin : g_free
    assign disNext[i] = strobe.loadFree ? wrData[i] : disQ[i];
  end

  always_comb begin
    if (strobe.clearLow)     disNext[IDX_LOW] = 1'b0;
    else if (strobe.loadLow) disNext[IDX_LOW] = wrData[IDX_LOW];
    else                     disNext[IDX_LOW] = disQ[IDX_LOW];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      disQ <= '0;
      oeQ  <= '1;
    end else begin
      disQ <= disNext;
      oeQ  <= ~disNext;
    end
  end
endmodule

// File: rtl/clk_out_dis_reg.sv
module clk_out_dis_reg
  import clk_out_dis_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [DIS_W-1:0] wrData,
  input  logic             swResetA,
  input  logic             swResetB,
  output logic [DIS_W-1:0] rdData,
  output logic             oeXtal,
  output logic             oeMid,
  output logic             oeLow
);
  disStrobe_t       strobe;
  logic [DIS_W-1:0] oeQ;

  clk_out_dis_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn),
    .swResetA(swResetA), .swResetB(swResetB), .strobe(strobe)
  );

  clk_out_dis_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrData(wrData), .disQ(rdData), .oeQ(oeQ)
  );

  assign oeXtal = oeQ[IDX_XTAL];
  assign oeMid  = oeQ[IDX_MID];
  assign oeLow  = oeQ[IDX_LOW];
endmodule

// File: rtl/clk_out_dis_chk.sv
module clk_out_dis_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [2:0] wrData,
  input logic       swResetA,
  input logic       swResetB,
  input logic [2:0] rdData,
  input logic       oeXtal,
  input logic       oeMid,
  input logic       oeLow
);
  AST_FREE_BITS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (rdData[1:0] == $past(wrData[1:0]))); // R2

  AST_OE_TRACKS_DIS: assert property (@(posedge clk) disable iff (!rstN)
    ({oeLow, oeMid, oeXtal} == ~rdData)); // R3

  AST_LOW_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[2] && !swResetA && !swResetB) |=> rdData[2]); // R4

  AST_SW_CLEAR_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (swResetA || swResetB) |=> (!rdData[2] && oeLow)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !swResetA && !swResetB) |=> $stable(rdData)); // R7
endmodule

bind clk_out_dis_reg clk_out_dis_chk chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
  .swResetA(swResetA), .swResetB(swResetB), .rdData(rdData),
  .oeXtal(oeXtal), .oeMid(oeMid), .oeLow(oeLow)
);

// File: tb/clk_out_dis_reg_tb.sv
module clk_out_dis_reg_tb_top;
  typedef struct {
    logic [2:0] rd;
    logic [2:0] oe;
    string      req;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrData = '0;
  logic       swResetA = 1'b0;
  logic       swResetB = 1'b0;
  logic [2:0] rdData;
  logic       oeXtal, oeMid, oeLow;

  expItem_t expQ[$];
  int checks = 0;
  int failures = 0;
  logic [2:0] mDis = '0;
  logic       mLock = 1'b0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  clk_out_dis_reg dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .swResetA(swResetA), .swResetB(swResetB), .rdData(rdData),
    .oeXtal(oeXtal), .oeMid(oeMid), .oeLow(oeLow)
  );

  // Monitor: compares one expected item per clock, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        checks++;
        if (rdData !== it.rd || {oeLow, oeMid, oeXtal} !== it.oe) begin
          failures++;
          $display("FAIL %s: rd=%b oe=%b expected rd=%b oe=%b",
                   it.req, rdData, {oeLow, oeMid, oeXtal}, it.rd, it.oe);
        end
      end
    end
  end

  task automatic step(input logic we, input logic [2:0] wd,
                      input logic sa, input logic sb, input string req);
    expItem_t it;
    @(negedge clk);
    wrEn = we; wrData = wd; swResetA = sa; swResetB = sb;
    if (we) mDis[1:0] = wd[1:0];
    if (sa || sb) begin
      mDis[2] = 1'b0; mLock = 1'b0;
    end else if (we) begin
      if (!mLock) mDis[2] = wd[2];
      mLock = 1'b1;
    end
    it.rd = mDis; it.oe = ~mDis; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic hwReset();
    @(negedge clk);
    wrEn = 0; swResetA = 0; swResetB = 0;
    @(negedge clk);
    rstN = 1'b0;
    mDis = '0; mLock = 1'b0;
    #1;
    checks++;
    if (rdData !== 3'b000 || {oeLow, oeMid, oeXtal} !== 3'b111) begin
      failures++;
      $display("FAIL R8: async reset rd=%b oe=%b expected rd=000 oe=111",
               rdData, {oeLow, oeMid, oeXtal});
    end
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #20000;
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step(0, 3'b000, 0, 0, "R8 reset state");
    step(1, 3'b011, 0, 0, "R1 R2 R9 free bits set, first write stores 0 to bit2");
    step(1, 3'b100, 0, 0, "R5 lock set by zero write, bit2 ignored");
    step(1, 3'b001, 0, 0, "R2 R3 mid cleared freely");
    step(0, 3'b000, 1, 0, "R6 swResetA re-arms lock");
    step(1, 3'b100, 0, 0, "R4 first write after sw reset sets low disable");
    step(1, 3'b000, 0, 0, "R4 later write cannot clear low disable");
    step(1, 3'b111, 0, 0, "R1 R2 free bits set while low locked");
    step(0, 3'b000, 0, 0, "R7 idle hold");
    step(0, 3'b010, 0, 0, "R7 data without strobe ignored");
    step(0, 3'b000, 0, 1, "R6 swResetB clears low disable");
    step(1, 3'b111, 1, 0, "R6 sw reset wins over same-cycle write to bit2");
    step(1, 3'b110, 0, 0, "R4 lock cleared by sw reset, write accepted");
    step(1, 3'b010, 0, 0, "R4 write ignored after lock");
    hwReset();
    step(0, 3'b000, 0, 0, "R8 state after hardware reset");
    step(1, 3'b101, 0, 0, "R1 R3 R4 write after hardware reset");
    step(1, 3'b000, 0, 0, "R1 R4 crystal clears, low stays");
    step(0, 3'b000, 0, 0, "R7 final hold");
    @(negedge clk);
    wrEn = 0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule